// File: doc/BRIEF.md
# Edge-Aligned PWM Timer with Wrap-Synchronised Settings

This block is a 16-bit up-counter shared by several compare channels. Each channel makes one single-slope PWM waveform that is aligned to the start of the period. The counter advances only on cycles where an external prescaler tick is high. It climbs from zero to a programmable period limit (TOP) and then returns to zero. So one period lasts TOP+1 ticks.

Each channel has a compare value and a polarity bit. In the normal polarity the pin is low at the start of a period and goes high once the count reaches the compare value. The inverted polarity gives the complement. Two compare values are fixed cases with a constant output: zero, and values at or above TOP. Software writes the period limit and the compare values into holding registers. The counter copies them into the working registers only when it wraps back to zero, so a change never cuts a period short or produces a runt pulse.

Each channel also has a sticky match flag, which a write-one strobe clears. A one-cycle wrap pulse marks the start of each period.

Top module: `ssp_pwm`

## Requirements
- R1: On each cycle with `tick_en` high, the counter goes from its value to value+1. When the counter equals the working TOP it goes to 0 instead, so a period is TOP+1 ticks long. `ovf_pulse` is high for exactly the one cycle after the edge that loads 0 from TOP, provided TOP is non-zero.
- R2: While `tick_en` is low, the counter, the working registers, `pwm_out` and the set side of `match_flag` keep their values.
- R3: A channel with `pol_inv`=0 and compare value C, where 0 < C < TOP, is low while the count is below C. It is high while the count is from C up to TOP.
- R4: A channel with `pol_inv`=1 drives the complement of the R3 waveform, and also the complement of the R7 and R8 levels.
- R5: A write on `top_wr` changes the period only from the next wrap onward. A write made in the same cycle as a wrap is used by that wrap.
- R6: A write on `cmp_wr[n]` changes channel n's duty only from the next wrap onward. A write made in the same cycle as a wrap is used by that wrap.
- R7: If a channel's working compare value is greater than or equal to the working TOP, the channel sits at its inactive level for the whole period: low when `pol_inv`=0, high when `pol_inv`=1.
- R8: If a channel's working compare value is 0, the channel sits at its active level for the whole period: high when `pol_inv`=0, low when `pol_inv`=1.
- R9: `match_flag[n]` becomes 1 on the tick edge that loads the counter with channel n's working compare value, and then stays at 1. It returns to 0 on a cycle with `flag_clr[n]` high. If a set and a clear fall on the same edge, the set wins.
- R10: A change of `pol_inv[n]` shows on `pwm_out[n]` in the same cycle, without waiting for a clock edge or a wrap.
- R11: While `rst_n` is low, the following apply:
  - The counter, all compare registers and all flags are 0.
  - Both TOP registers are 0xFFFF.
  - `ovf_pulse` is 0.
  - Each `pwm_out[n]` equals `pol_inv[n]` (the inactive level). It keeps that level until the first wrap after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaler tick; counter advances when high |
| top_wr | input | 1 | Write strobe for the TOP holding register |
| top_wdata | input | CW | Period limit value to write |
| cmp_wr | input | NCH | Per-channel write strobes for compare holding registers |
| cmp_wdata | input | NCH*CW | Compare values; channel n uses bits [n*CW +: CW] |
| pol_inv | input | NCH | Per-channel polarity: 0 normal, 1 inverted |
| flag_clr | input | NCH | Per-channel write-one-to-clear for match flags |
| pwm_out | output | NCH | PWM pins |
| match_flag | output | NCH | Sticky compare-match flags |
| ovf_pulse | output | 1 | One-cycle pulse at each TOP-to-zero wrap |

## Verification
The hardest case to reach is a holding-register write that lands exactly in the cycle of a wrap, because the write has to meet a period boundary that moves with the previous settings. The stimulus handles this in two steps. It first locks onto a wrap pulse. It then counts ticks through the known period and loads each next vector either early in the current period or on the last count before the wrap, alternating between the two. This proves that later writes leave the current period intact, and that a write coinciding with the wrap still takes effect there. A further pass toggles the tick every other cycle, which checks that the period stretches and that the outputs hold between ticks.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int CNT_W_DEF = 16;
  localparam int NCH_DEF   = 4;

  typedef enum logic {
    POL_NORMAL = 1'b0,
    POL_INVERT = 1'b1
  } pol_e;
endpackage

// File: rtl/ssp_timebase.sv
module ssp_timebase #(
  parameter int CW = ssp_pkg::CNT_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          top_wr,
  input  logic [CW-1:0] top_wdata,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic [CW-1:0] top_o,
  output logic [CW-1:0] top_nxt_o,
  output logic          wrap_o,
  output logic          run_o,
  output logic          run_nxt_o,
  output logic          ovf_o
);
  localparam logic [CW-1:0] TOP_RST  = '1;
  localparam logic [CW-1:0] CNT_ZERO = '0;
  localparam logic [CW-1:0] CNT_ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] top_act_q, top_act_d;
  logic [CW-1:0] top_sh_q, top_sh_d;
  logic          run_q, run_d;
  logic          ovf_q, ovf_d;
  logic          wrap;

  // next-state
  always_comb begin
    wrap      = tick_en && (cnt_q >= top_act_q);
    top_sh_d  = top_wr ? top_wdata : top_sh_q;
    cnt_d     = cnt_q;
    if (tick_en) begin
      cnt_d = wrap ? CNT_ZERO : (cnt_q + CNT_ONE);
    end
    top_act_d = wrap ? top_sh_d : top_act_q;
    run_d     = run_q | wrap;
    ovf_d     = wrap;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= CNT_ZERO;
      top_act_q <= TOP_RST;
      top_sh_q  <= TOP_RST;
      run_q     <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      top_act_q <= top_act_d;
      top_sh_q  <= top_sh_d;
      run_q     <= run_d;
      ovf_q     <= ovf_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
  assign top_o     = top_act_q;
  assign top_nxt_o = top_act_d;
  assign wrap_o    = wrap;
  assign run_o     = run_q;
  assign run_nxt_o = run_d;
  assign ovf_o     = ovf_q;

  AST_CNT_WITHIN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= top_act_q); // R1
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && top_act_q != CNT_ZERO) |=> !ovf_q); // R1
  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> cnt_q == CNT_ZERO); // R1
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q) && $stable(top_act_q)); // R2
  AST_TOP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(top_act_q) |-> cnt_q == CNT_ZERO); // R5
endmodule

// File: rtl/ssp_chan.sv
module ssp_chan #(
  parameter int CW = ssp_pkg::CNT_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wrap_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cnt_nxt_i,
  input  logic [CW-1:0] top_i,
  input  logic [CW-1:0] top_nxt_i,
  input  logic          run_i,
  input  logic          run_nxt_i,
  input  logic          cmp_wr,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          pol_inv,
  input  logic          flag_clr,
  output logic          pwm_o,
  output logic          flag_o
);
  import ssp_pkg::*;

  localparam logic [CW-1:0] CMP_ZERO = '0;

  logic [CW-1:0] cmp_sh_q, cmp_sh_d;
  logic [CW-1:0] cmp_act_q, cmp_act_d;
  logic          raw_q, raw_d;
  logic          flag_q, flag_d;
  logic          hit;
  pol_e          pol;

  // active (non-inverted) level for a given count, compare and period
  function automatic logic active_lvl(input logic [CW-1:0] c,
                                      input logic [CW-1:0] cmp,
                                      input logic [CW-1:0] top);
    if (cmp == CMP_ZERO)  return 1'b1;
    else if (cmp >= top)  return 1'b0;
    else                  return (c >= cmp);
  endfunction

  // next-state
  always_comb begin
    cmp_sh_d  = cmp_wr ? cmp_wdata : cmp_sh_q;
    cmp_act_d = wrap_i ? cmp_sh_d : cmp_act_q;
    hit       = tick_en && (cnt_nxt_i == cmp_act_d);
    raw_d     = raw_q;
    if (tick_en) begin
      raw_d = run_nxt_i && active_lvl(cnt_nxt_i, cmp_act_d, top_nxt_i);
    end
    flag_d    = hit | (flag_q & ~flag_clr);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_sh_q  <= CMP_ZERO;
      cmp_act_q <= CMP_ZERO;
      raw_q     <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      cmp_sh_q  <= cmp_sh_d;
      cmp_act_q <= cmp_act_d;
      raw_q     <= raw_d;
      flag_q    <= flag_d;
    end
  end

  assign pol    = pol_e'(pol_inv);
  assign pwm_o  = (pol == POL_INVERT) ? ~raw_q : raw_q;
  assign flag_o = flag_q;

  AST_CMP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_act_q) |-> cnt_i == CMP_ZERO); // R6
  AST_CMP_SAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act_q != CMP_ZERO && cmp_act_q >= top_i) |-> !raw_q); // R7
  AST_CMP_ZERO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && cmp_act_q == CMP_ZERO) |-> raw_q); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q); // R9
  AST_IDLE_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !raw_q); // R11
endmodule

// File: rtl/ssp_pwm.sv
module ssp_pwm #(
  parameter int CW  = ssp_pkg::CNT_W_DEF,
  parameter int NCH = ssp_pkg::NCH_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              top_wr,
  input  logic [CW-1:0]     top_wdata,
  input  logic [NCH-1:0]    cmp_wr,
  input  logic [NCH*CW-1:0] cmp_wdata,
  input  logic [NCH-1:0]    pol_inv,
  input  logic [NCH-1:0]    flag_clr,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH-1:0]    match_flag,
  output logic              ovf_pulse
);
  logic [CW-1:0] cnt, cnt_nxt, top_act, top_nxt;
  logic          wrap, run, run_nxt;

  ssp_timebase #(.CW(CW)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .top_wr    (top_wr),
    .top_wdata (top_wdata),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .top_o     (top_act),
    .top_nxt_o (top_nxt),
    .wrap_o    (wrap),
    .run_o     (run),
    .run_nxt_o (run_nxt),
    .ovf_o     (ovf_pulse)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    ssp_chan #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .wrap_i    (wrap),
      .cnt_i     (cnt),
      .cnt_nxt_i (cnt_nxt),
      .top_i     (top_act),
      .top_nxt_i (top_nxt),
      .run_i     (run),
      .run_nxt_i (run_nxt),
      .cmp_wr    (cmp_wr[n]),
      .cmp_wdata (cmp_wdata[n*CW +: CW]),
      .pol_inv   (pol_inv[n]),
      .flag_clr  (flag_clr[n]),
      .pwm_o     (pwm_out[n]),
      .flag_o    (match_flag[n])
    );
  end
endmodule

// File: tb/ssp_pwm_tb.sv
`timescale 1ns/1ps
module ssp_pwm_tb;
  localparam int CW  = 16;
  localparam int NCH = 4;
  localparam int NV  = 6;

  // vector table: TOP, compare values {c3,c2,c1,c0}, polarity
  localparam logic [15:0] V_TOP [0:NV-1] = '{16'd7, 16'd4, 16'd9, 16'd3, 16'd12, 16'd5};
  localparam logic [63:0] V_CMP [0:NV-1] = '{
    {16'd9,  16'd7,     16'd3,  16'd0},
    {16'd0,  16'd4,     16'd2,  16'd1},
    {16'd1,  16'd10,    16'd9,  16'd5},
    {16'd1,  16'd3,     16'd0,  16'd2},
    {16'd12, 16'd0,     16'd6,  16'd11},
    {16'd2,  16'd3,     16'hFFFF, 16'd4}};
  localparam logic [3:0] V_INV [0:NV-1] = '{4'b0000, 4'b1010, 4'b0110, 4'b1111, 4'b0001, 4'b1000};

  logic              clk = 1'b0;
  logic              rst_n;
  logic              tick_en;
  logic              top_wr;
  logic [CW-1:0]     top_wdata;
  logic [NCH-1:0]    cmp_wr;
  logic [NCH*CW-1:0] cmp_wdata;
  logic [NCH-1:0]    pol_inv;
  logic [NCH-1:0]    flag_clr;
  logic [NCH-1:0]    pwm_out;
  logic [NCH-1:0]    match_flag;
  logic              ovf_pulse;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ssp_pwm #(.CW(CW), .NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .top_wr(top_wr),
    .top_wdata(top_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .pol_inv(pol_inv), .flag_clr(flag_clr), .pwm_out(pwm_out),
    .match_flag(match_flag), .ovf_pulse(ovf_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic exp_lvl(input int i, input int c, input int t, input logic inv);
    logic a;
    a = (c == 0) || (c < t && i >= c);
    return a ^ inv;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cycles;
    logic [NCH-1:0] prev;
    rst_n = 1'b0; tick_en = 1'b0; top_wr = 1'b0; top_wdata = '0;
    cmp_wr = '0; cmp_wdata = '0; pol_inv = 4'b0101; flag_clr = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(pwm_out == pol_inv, "R11 pwm", int'(pwm_out), int'(pol_inv));
    chk(match_flag == '0, "R11 flag", int'(match_flag), 0);
    chk(ovf_pulse == 1'b0, "R11 ovf", int'(ovf_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    tick_en = 1'b1; top_wr = 1'b1; top_wdata = V_TOP[0];
    cmp_wr = '1; cmp_wdata = V_CMP[0];
    @(negedge clk);
    top_wr = 1'b0; cmp_wr = '0;
    repeat (100) @(negedge clk);
    // R11: inactive until first wrap; R5: new TOP not yet in use
    chk(pwm_out == pol_inv, "R11 hold", int'(pwm_out), int'(pol_inv));
    chk(ovf_pulse == 1'b0, "R5 no early wrap", int'(ovf_pulse), 0);
    while (!ovf_pulse) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int t;
      int wr_at;
      bit wrote;
      t     = int'(V_TOP[v]);
      wr_at = (v % 2 == 1) ? t : 1;
      wrote = 1'b0;
      top_wr = 1'b0; cmp_wr = '0;
      pol_inv = V_INV[v]; flag_clr = '1;
      #1;
      chk(ovf_pulse == 1'b1, "R1 wrap pulse", int'(ovf_pulse), 1);
      for (int i = 0; i <= t; i++) begin
        if (i > 0) begin
          @(negedge clk);
          flag_clr = '0; top_wr = 1'b0; cmp_wr = '0;
          chk(ovf_pulse == 1'b0, wrote ? "R5 period kept" : "R1 no pulse",
              int'(ovf_pulse), 0);
        end
        for (int ch = 0; ch < NCH; ch++) begin
          int c;
          logic e;
          string tag;
          c = int'(V_CMP[v][ch*16 +: 16]);
          e = exp_lvl(i, c, t, V_INV[v][ch]);
          if (wrote)            tag = "R6 duty kept";
          else if (c == 0)      tag = "R8 zero cmp";
          else if (c >= t)      tag = "R7 sat cmp";
          else if (V_INV[v][ch]) tag = "R4 inverted";
          else                  tag = "R3 normal";
          chk(pwm_out[ch] == e, tag, int'(pwm_out[ch]), int'(e));
          if (i == t) begin
            logic ef;
            ef = (c >= 1) && (c <= t);
            chk(match_flag[ch] == ef, "R9 flag", int'(match_flag[ch]), int'(ef));
          end
        end
        if (v < NV - 1 && i == wr_at) begin
          top_wr = 1'b1; top_wdata = V_TOP[v+1];
          cmp_wr = '1;   cmp_wdata = V_CMP[v+1];
          wrote  = 1'b1;
        end
      end
      @(negedge clk);
    end

    // R1/R2: tick every other cycle doubles the period, outputs hold between ticks
    top_wr = 1'b0; cmp_wr = '0; flag_clr = '0;
    cycles = 0;
    for (int k = 0; k < 20; k++) begin
      prev = pwm_out;
      tick_en = 1'b0;
      @(negedge clk);
      chk(pwm_out == prev, "R2 hold pwm", int'(pwm_out), int'(prev));
      chk(ovf_pulse == 1'b0, "R2 no wrap", int'(ovf_pulse), 0);
      tick_en = 1'b1;
      @(negedge clk);
      cycles += 2;
      if (ovf_pulse) break;
    end
    chk(cycles == 12, "R1 period", cycles, 12);

    // R10: polarity change is immediate
    @(negedge clk);
    prev = pwm_out;
    pol_inv = pol_inv ^ 4'b0001;
    #1;
    chk(pwm_out[0] == ~prev[0], "R10 polarity", int'(pwm_out[0]), int'(~prev[0]));

    // R9: clear strobe empties flags
    flag_clr = '1; tick_en = 1'b0;
    @(negedge clk);
    chk(match_flag == '0, "R9 clear", int'(match_flag), 0);
    flag_clr = '0;

    // R11: reset in mid-run
    rst_n = 1'b0;
    #1;
    chk(pwm_out == pol_inv, "R11 rerun pwm", int'(pwm_out), int'(pol_inv));
    chk(ovf_pulse == 1'b0, "R11 rerun ovf", int'(ovf_pulse), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule